// File: doc/BRIEF.md
# EEPROM Page Write Engine

This block sits behind the serial command decoder of a small serial EEPROM. Once a write command has been decoded, the decoder hands over the start address with a one-cycle strobe. Each data byte that follows arrives with its own one-cycle strobe. The engine collects the bytes in a page buffer of `PAGE_BYTES` entries. Only the low in-page address bits advance from byte to byte, so a long burst wraps around inside the page and the later bytes overwrite the earlier ones.

When chip select rises, the decoder presents a one-cycle event together with two indications. The first says whether the rise fell exactly on a byte boundary. The second says whether writing is currently permitted, which covers the protect pin, the write-enable latch and the protection range. The engine commits the page only if both indications are true and at least one byte was received; in every other case the page is dropped and the engine returns to standby. A commit starts a self-timed write cycle that lasts `WRITE_CYCLES` system clocks. During the first `PAGE_BYTES` clocks of that cycle, each location that actually received a byte is written to the array once. The engine raises `busy` for the whole cycle. It pulses `writeDone` in the final cycle, and the status logic uses that pulse to clear its write-enable latch.

Top module: `pw_engine`

## Requirements
- R1: After reset, `busy`, `writeDone` and `memWe` are all 0.
- R2: The byte that arrives k-th after a start address A (k counting from 0) is written to the address whose upper bits are A's upper bits and whose low log2(PAGE_BYTES) bits are (A + k) mod PAGE_BYTES.
- R3: If more than PAGE_BYTES bytes arrive, the in-page position wraps and the array holds the last byte received for each location.
- R4: A chip-select rise with `byteAligned` = 0 discards the page: no array write, and `busy` stays 0.
- R5: A chip-select rise with `writePermit` = 0 discards the page: no array write, `busy` stays 0 and no `writeDone` is produced.
- R6: On a committing chip-select rise, `busy` is 1 from the next cycle for exactly WRITE_CYCLES cycles, and `writeDone` is 1 for exactly one cycle, the last cycle of that window.
- R7: During a write cycle, exactly the locations that received bytes are written, each one once, and `memWe` is asserted only while `busy` is 1.
- R8: Start strobes, byte strobes and chip-select rises that arrive while `busy` is 1 are ignored: they cause no array write and no further write cycle.
- R9: A chip-select rise after a start address, when no byte has been received, starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | One-cycle strobe: start address of a new write command |
| startAddr | input | ADDR_W | Start address, valid with `startValid` |
| byteValid | input | 1 | One-cycle strobe: a data byte has been received |
| byteData | input | DATA_W | Data byte, valid with `byteValid` |
| csRise | input | 1 | One-cycle event: chip select went high |
| byteAligned | input | 1 | The chip-select rise came exactly after a byte's last bit |
| writePermit | input | 1 | Writing is allowed, sampled with `csRise` |
| busy | output | 1 | Self-timed write cycle in progress |
| writeDone | output | 1 | One-cycle pulse in the final cycle of the write cycle |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memData | output | DATA_W | Array write data |

## Verification
The bench goes after bursts that start in the middle of a page and cross the page end. An engine that carried into the upper address bits would write into the neighbouring page, and the full-array comparison would show it. Bursts of more than a page test the overwrite order: one that kept the first byte, or wrote a location twice, shows a wrong value or a duplicate-write count. Rises off a byte boundary, rises without permission and rises on an empty page must leave the array untouched with `busy` low. Strobes injected in the middle of a write cycle must not start a second cycle, and the length of the `busy` window and the place of `writeDone` within it are counted cycle by cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // Strobes from the control FSM to the page datapath
  typedef struct packed {
    logic load;    // latch start address, clear received mask
    logic store;   // store one byte at the in-page pointer
    logic commit;  // write cycle begins: rewind the scan index
    logic scan;    // present one page slot to the array this cycle
  } pwStrobes_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 2000,
  localparam int TIMER_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       byteValid,
  input  logic       csRise,
  input  logic       byteAligned,
  input  logic       writePermit,
  input  logic       pageHasData,
  output pwStrobes_t strobes,
  output logic       busy,
  output logic       writeDone
);
  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_PROGRAM} pwState_e;

  localparam logic [TIMER_W-1:0] LAST_TICK = TIMER_W'(WRITE_CYCLES - 1);
  localparam logic [TIMER_W-1:0] SCAN_END  = TIMER_W'(PAGE_BYTES);

  pwState_e state, stateNext;
  logic [TIMER_W-1:0] timer;
  logic lastTick;

  assign lastTick = (state == S_PROGRAM) && (timer == LAST_TICK);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      S_IDLE: begin
        if (startValid) begin
          strobes.load = 1'b1;
          stateNext    = S_COLLECT;
        end
      end
      S_COLLECT: begin
        if (startValid) begin
          strobes.load = 1'b1;
        end else begin
          strobes.store = byteValid;
          if (csRise) begin
            if (byteAligned && writePermit && (pageHasData || byteValid)) begin
              strobes.commit = 1'b1;
              stateNext      = S_PROGRAM;
            end else begin
              stateNext = S_IDLE;
            end
          end
        end
      end
      S_PROGRAM: begin
        strobes.scan = (timer < SCAN_END);
        if (lastTick) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      timer <= '0;
    end else begin
      state <= stateNext;
      if (strobes.commit)      timer <= '0;
      else if (state == S_PROGRAM) timer <= timer + 1'b1;
    end
  end

  assign busy      = (state == S_PROGRAM);
  assign writeDone = lastTick;
endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int BASE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobes_t        strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  output logic              pageHasData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  logic [BASE_W-1:0]     pageBase;
  logic [IDX_W-1:0]      fillPtr;
  logic [IDX_W-1:0]      scanIdx;
  logic [PAGE_BYTES-1:0] rxMask;
  logic [DATA_W-1:0]     slotData [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageBase <= '0;
      fillPtr  <= '0;
      scanIdx  <= '0;
    end else begin
      if (strobes.load) begin
        pageBase <= startAddr[ADDR_W-1:IDX_W];
        fillPtr  <= startAddr[IDX_W-1:0];
      end else if (strobes.store) begin
        fillPtr <= fillPtr + 1'b1;  // wraps inside the page
      end
      if (strobes.commit)    scanIdx <= '0;
      else if (strobes.scan) scanIdx <= scanIdx + 1'b1;
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic hit;
    assign hit = strobes.store && (fillPtr == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxMask[s]   <= 1'b0;
        slotData[s] <= '0;
      end else begin
        if (strobes.load)  rxMask[s] <= 1'b0;
        else if (hit)      rxMask[s] <= 1'b1;
        if (hit) slotData[s] <= byteData;
      end
    end
  end

  assign pageHasData = |rxMask;
  assign memWe       = strobes.scan && rxMask[scanIdx];
  assign memAddr     = {pageBase, scanIdx};
  assign memData     = slotData[scanIdx];
endmodule

// File: rtl/pw_engine.sv
module pw_engine
  import pw_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              csRise,
  input  logic              byteAligned,
  input  logic              writePermit,
  output logic              busy,
  output logic              writeDone,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  pwStrobes_t strobes;
  logic pageHasData;

  pw_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .byteValid(byteValid),
    .csRise(csRise), .byteAligned(byteAligned), .writePermit(writePermit),
    .pageHasData(pageHasData), .strobes(strobes), .busy(busy),
    .writeDone(writeDone)
  );

  pw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startAddr(startAddr),
    .byteData(byteData), .pageHasData(pageHasData), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/pw_engine_chk.sv
module pw_engine_chk #(
  parameter int WRITE_CYCLES = 2000,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input logic clk,
  input logic rstN,
  input logic csRise,
  input logic byteAligned,
  input logic writePermit,
  input logic busy,
  input logic writeDone,
  input logic memWe
);
  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R7: array writes only inside the write cycle
  p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R6: the done pulse closes the busy window
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    writeDone |=> !busy);

  // R6: done arrives in the last counted cycle of the window
  p_done_length_r6: assert property (@(posedge clk) disable iff (!rstN)
    writeDone |-> (busy && busyCnt == CNT_W'(WRITE_CYCLES - 1)));

  // R6, R8: a write cycle only begins right after a committing rise
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise && byteAligned && writePermit));

  // R4: misaligned rise never starts a cycle
  p_misaligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && csRise && !byteAligned) |=> !busy);

  // R5: rise without permission never starts a cycle
  p_no_permit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && csRise && !writePermit) |=> !busy);
endmodule

bind pw_engine pw_engine_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csRise(csRise), .byteAligned(byteAligned),
  .writePermit(writePermit), .busy(busy), .writeDone(writeDone), .memWe(memWe)
);

// File: tb/sim_pw_engine.sv
`timescale 1ns/1ps
module sim_pw_engine;
  localparam int ADDR_W = 9, DATA_W = 8, PAGE = 8, WC = 24;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rstN = 0;
  logic startValid = 0, byteValid = 0, csRise = 0, byteAligned = 0, writePermit = 0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [DATA_W-1:0] byteData = '0;
  logic busy, writeDone, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;

  pw_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .byteAligned(byteAligned), .writePermit(writePermit), .busy(busy),
    .writeDone(writeDone), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] arr [DEPTH];
  logic [DATA_W-1:0] refArr [DEPTH];
  int hits [DEPTH];
  int weCount = 0, strayWe = 0;

  // array model: sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && memWe) begin
      arr[memAddr] = memData;
      hits[memAddr]++;
      weCount++;
      if (!busy) strayWe++;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int arrMismatches();
    int n = 0;
    for (int a = 0; a < DEPTH; a++) if (arr[a] !== refArr[a]) n++;
    return n;
  endfunction

  function automatic int dupHits();
    int n = 0;
    for (int a = 0; a < DEPTH; a++) if (hits[a] > 1) n++;
    return n;
  endfunction

  // one write command; poke injects strobes in the middle of a write cycle
  task automatic runWrite(input string req, input int sAddr, input int nBytes,
                          input bit aligned, input bit permit, input bit poke);
    logic [DATA_W-1:0] expBuf [PAGE];
    bit expMask [PAGE];
    int expWrites = 0, busyLen = 0, doneCnt = 0, doneAtLast = 0;
    bit commit;
    for (int i = 0; i < PAGE; i++) expMask[i] = 0;
    for (int a = 0; a < DEPTH; a++) hits[a] = 0;
    weCount = 0; strayWe = 0;
    @(negedge clk);
    startValid = 1; startAddr = ADDR_W'(sAddr);
    @(negedge clk);
    startValid = 0;
    for (int k = 0; k < nBytes; k++) begin
      int loc = (sAddr + k) % PAGE;
      int gap = $urandom_range(0, 2);
      byteValid = 1; byteData = DATA_W'($urandom);
      expBuf[loc] = byteData; expMask[loc] = 1;
      @(negedge clk);
      byteValid = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    csRise = 1; byteAligned = aligned; writePermit = permit;
    @(negedge clk);
    csRise = 0; byteAligned = 0; writePermit = 0;
    commit = aligned && permit && (nBytes > 0);
    if (commit) begin
      int base = sAddr - (sAddr % PAGE);
      for (int i = 0; i < PAGE; i++)
        if (expMask[i]) begin refArr[base + i] = expBuf[i]; expWrites++; end
      while (busy && busyLen < WC + 10) begin
        busyLen++;
        if (writeDone) begin doneCnt++; if (busyLen == WC) doneAtLast = 1; end
        if (poke) begin
          startValid  = (busyLen == 3);
          startAddr   = ADDR_W'(sAddr ^ 8);
          byteValid   = (busyLen == 4);
          byteData    = 8'h5A;
          csRise      = (busyLen == 5);
          byteAligned = (busyLen == 5);
          writePermit = (busyLen == 5);
        end
        @(negedge clk);
      end
      startValid = 0; byteValid = 0; csRise = 0; byteAligned = 0; writePermit = 0;
      check("R6", busyLen, WC, {req, " busy window length"});
      check("R6", doneCnt, 1, {req, " done pulse count"});
      check("R6", doneAtLast, 1, {req, " done in last busy cycle"});
      for (int w = 0; w < WC + 4; w++) begin
        if (busy) busyLen++;
        @(negedge clk);
      end
      if (poke) check("R8", busyLen, WC, {req, " no second cycle after injected strobes"});
    end else begin
      for (int w = 0; w < WC + 4; w++) begin
        if (busy) busyLen++;
        @(negedge clk);
      end
      check(req, busyLen, 0, "busy cycles on dropped command");
    end
    check(req, weCount, expWrites, "array write count");
    check("R7", dupHits(), 0, {req, " locations written twice"});
    check("R7", strayWe, 0, {req, " writes outside busy"});
    check(req, arrMismatches(), 0, "array mismatches");
  endtask

  initial begin
    #(5ns * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    for (int a = 0; a < DEPTH; a++) begin arr[a] = 8'hFF; refArr[a] = 8'hFF; end
    repeat (3) @(negedge clk);
    check("R1", busy, 0, "busy at reset");
    check("R1", writeDone, 0, "done at reset");
    check("R1", memWe, 0, "write enable at reset");
    rstN = 1;
    @(negedge clk);
    check("R1", busy, 0, "busy after reset release");

    runWrite("R2", 9'h040, 1, 1, 1, 0);       // single byte
    runWrite("R2", 9'h0AD, 8, 1, 1, 0);       // mid-page start, wraps in page
    runWrite("R3", 9'h113, 11, 1, 1, 0);      // overlong burst overwrites
    runWrite("R3", 9'h1F8, 17, 1, 1, 0);      // two full wraps at top page
    runWrite("R4", 9'h020, 5, 0, 1, 0);       // off byte boundary
    runWrite("R5", 9'h060, 4, 1, 0, 0);       // not permitted
    runWrite("R9", 9'h070, 0, 1, 1, 0);       // empty page
    runWrite("R8", 9'h0C2, 3, 1, 1, 1);       // strobes during busy
    for (int t = 0; t < 24; t++) begin
      int sA = $urandom_range(0, DEPTH - 1);
      int nB = $urandom_range(0, 12);
      bit al = ($urandom_range(0, 4) != 0);
      bit pm = ($urandom_range(0, 4) != 0);
      runWrite((al && pm && nB > 0) ? "R2" : (!al ? "R4" : (!pm ? "R5" : "R9")),
               sA, nB, al, pm, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule